// File: doc/BRIEF.md
# Execution-Phase Byte Transfer Handshake

This block paces the movement of data bytes between a disk controller core and the system while a command is in its execution phase. It assumes no byte buffering. Each time the core signals that one byte is ready, the block asks for service in one of two ways:

- **DMA mode:** it raises a request line for a system DMA engine. It withdraws the request when that engine lowers its active-low acknowledge. The byte is taken when a read or write strobe arrives while the acknowledge is held low.
- **Host-serviced mode:** it raises an interrupt and a pollable status flag. Both stay up until the host touches the data port.

A byte counter is loaded when execution starts. The byte that brings the counter to zero ends the execution phase. The block then raises an interrupt that announces the result phase. That interrupt stays asserted until the host reads the first result byte.

The mode is chosen when execution starts, from two control bits. One bit comes from the drive-timing parameters and must be 0 to allow DMA. The other is the DMA-enable bit of the output control register and must be 1.

Top module: `xfer_hshk`

## Requirements
- R1: At `start` the block latches DMA mode when `spec_pio_bit` is 0 and `dor_dma_bit` is 1; any other pair selects host-serviced mode. Changes to these inputs later in the same transfer have no effect. `drq` and `poll_flag` are never high together.
- R2: In DMA mode during execution, `byte_rdy` sampled with `dack_n` high makes `drq` high from the next cycle.
- R3: A falling edge of `dack_n` clears `drq` from the next cycle. A falling edge means `dack_n` was sampled 1 and is now sampled 0.
- R4: In DMA mode, `byte_rdy` sampled while `dack_n` is low is held pending. `drq` rises only in the cycle after `dack_n` is first sampled high again.
- R5: In DMA mode, a byte completes only on `io_rd` or `io_wr` sampled with `dack_n` low, after the request was raised, while that byte is outstanding. A strobe with `dack_n` high changes nothing.
- R6: In host-serviced mode, `byte_rdy` sets `irq` and `poll_flag` from the next cycle. Both hold until `io_rd` or `io_wr` completes the byte. A strobe with no byte pending does not count a byte.
- R7: `start` in idle loads the counter from `xfer_count`. A transfer has not ended while `exec_busy` is 1. The completion that takes the counter from 1 to 0 drops `exec_busy` and raises `irq` in the next cycle. A count of 0 enters the result phase directly.
- R8: In the result phase `irq` stays high until `res_rd` is sampled. The block is then idle with `irq` low in the next cycle.
- R9: Outside the execution phase, `byte_rdy`, `io_rd` and `io_wr` have no effect. `drq` is low and no stale request carries into the next transfer.
- R10: After synchronous reset, `drq`, `irq`, `poll_flag` and `exec_busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: execution phase begins |
| xfer_count | input | CNT_W | Bytes to move, loaded at start |
| spec_pio_bit | input | 1 | Timing-parameter bit; 0 permits DMA |
| dor_dma_bit | input | 1 | Output-control DMA enable; 1 permits DMA |
| byte_rdy | input | 1 | Core strobe: one byte ready |
| dack_n | input | 1 | Active-low DMA acknowledge |
| io_rd | input | 1 | Data read strobe |
| io_wr | input | 1 | Data write strobe |
| res_rd | input | 1 | First result byte read |
| drq | output | 1 | DMA request |
| irq | output | 1 | Interrupt (per byte, or result phase) |
| poll_flag | output | 1 | Status flag: host transfer needed |
| exec_busy | output | 1 | Execution phase active |

## Verification
A wrong outstanding-byte or deferred-request flag shows up one cycle after the next acknowledge edge: `drq` is re-raised, stays high, or never rises. A counter that is off by one shows at the last byte: `exec_busy` falls one byte early or one byte late, and the result interrupt moves with it. A wrongly latched mode makes the first byte of a transfer show up on the wrong output, `drq` instead of `irq`, in the cycle after `byte_rdy`.

// File: rtl/xh_pkg.sv
package xh_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_EXEC   = 2'd1,
    PH_RESULT = 2'd2
  } phase_t;
endpackage

// File: rtl/xh_mode_latch.sv
module xh_mode_latch (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic spec_pio_bit,
  input  logic dor_dma_bit,
  output logic dma_q
);
  // DMA only when the timing bit permits it and the output register enables it
  always_ff @(posedge clk) begin
    if (rst)       dma_q <= 1'b0;
    else if (load) dma_q <= ~spec_pio_bit & dor_dma_bit;
  end
endmodule

// File: rtl/xh_bytecnt.sv
module xh_bytecnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic             at_one
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign at_one = (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst)                           cnt_q <= '0;
    else if (load)                     cnt_q <= load_val;
    else if (dec && cnt_q != '0)       cnt_q <= cnt_q - ONE;
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && cnt_q == '0) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/xh_dma_req.sv
module xh_dma_req (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic byte_rdy,
  input  logic dack_n,
  input  logic strobe,
  output logic drq,
  output logic done
);
  logic dack_q;   // acknowledge seen last cycle
  logic wait_q;   // byte ready, request held back while acknowledge low
  logic owe_q;    // byte outstanding

  assign done = en & owe_q & ~wait_q & ~dack_n & strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      dack_q <= 1'b1;
      wait_q <= 1'b0;
      owe_q  <= 1'b0;
      drq    <= 1'b0;
    end else begin
      dack_q <= dack_n;
      if (!en) begin
        wait_q <= 1'b0;
        owe_q  <= 1'b0;
        drq    <= 1'b0;
      end else begin
        if (done) begin
          owe_q <= 1'b0;
          drq   <= 1'b0;
        end else if (dack_q && !dack_n) begin
          drq <= 1'b0;
        end
        if (wait_q && dack_n) begin
          drq    <= 1'b1;
          wait_q <= 1'b0;
        end
        if (byte_rdy && !owe_q) begin
          owe_q <= 1'b1;
          if (dack_n) drq    <= 1'b1;
          else        wait_q <= 1'b1;
        end
      end
    end
  end

  AST_DACK_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (dack_q && !dack_n) |=> !drq); // R3
  AST_NO_RAISE_DACK_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(drq) |-> $past(dack_n)); // R4
  AST_DRQ_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
    drq |-> $past(en)); // R9
endmodule

// File: rtl/xh_pio_req.sv
module xh_pio_req (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic byte_rdy,
  input  logic strobe,
  output logic svc_q,
  output logic done
);
  assign done = en & svc_q & strobe;

  always_ff @(posedge clk) begin
    if (rst || !en)              svc_q <= 1'b0;
    else if (done)               svc_q <= 1'b0;
    else if (byte_rdy && !svc_q) svc_q <= 1'b1;
  end

  AST_SVC_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (svc_q && en && !strobe) |=> svc_q); // R6
endmodule

// File: rtl/xfer_hshk.sv
module xfer_hshk #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] xfer_count,
  input  logic             spec_pio_bit,
  input  logic             dor_dma_bit,
  input  logic             byte_rdy,
  input  logic             dack_n,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic             res_rd,
  output logic             drq,
  output logic             irq,
  output logic             poll_flag,
  output logic             exec_busy
);
  import xh_pkg::*;

  phase_t           st_q;
  logic             res_irq_q;
  logic             dma_q;
  logic             go;
  logic             in_exec;
  logic             strobe;
  logic             dma_done;
  logic             pio_done;
  logic             byte_done;
  logic             svc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_one;

  assign go        = start && (st_q == PH_IDLE);
  assign in_exec   = (st_q == PH_EXEC);
  assign strobe    = io_rd | io_wr;
  assign byte_done = dma_done | pio_done;

  xh_mode_latch u_mode (
    .clk(clk), .rst(rst), .load(go),
    .spec_pio_bit(spec_pio_bit), .dor_dma_bit(dor_dma_bit), .dma_q(dma_q)
  );

  xh_bytecnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(go), .load_val(xfer_count),
    .dec(byte_done), .cnt_q(cnt_q), .at_one(at_one)
  );

  xh_dma_req u_dma (
    .clk(clk), .rst(rst), .en(in_exec & dma_q), .byte_rdy(byte_rdy),
    .dack_n(dack_n), .strobe(strobe), .drq(drq), .done(dma_done)
  );

  xh_pio_req u_pio (
    .clk(clk), .rst(rst), .en(in_exec & ~dma_q), .byte_rdy(byte_rdy),
    .strobe(strobe), .svc_q(svc_q), .done(pio_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= PH_IDLE;
      res_irq_q <= 1'b0;
    end else begin
      unique case (st_q)
        PH_IDLE: if (start) begin
          if (xfer_count == '0) begin
            st_q      <= PH_RESULT;
            res_irq_q <= 1'b1;
          end else begin
            st_q <= PH_EXEC;
          end
        end
        PH_EXEC: if (byte_done && at_one) begin
          st_q      <= PH_RESULT;
          res_irq_q <= 1'b1;
        end
        PH_RESULT: if (res_rd) begin
          st_q      <= PH_IDLE;
          res_irq_q <= 1'b0;
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  assign irq       = res_irq_q | svc_q;
  assign poll_flag = svc_q;
  assign exec_busy = in_exec;

  AST_RESULT_IRQ: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_RESULT) |-> irq); // R8
  AST_EXEC_CNT_LIVE: assert property (@(posedge clk) disable iff (rst)
    in_exec |-> (cnt_q != '0)); // R7
  AST_ONE_PATH: assert property (@(posedge clk) disable iff (rst)
    !(drq && poll_flag)); // R1
  AST_RES_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_RESULT && res_rd) |=> (!irq && !exec_busy)); // R8
endmodule

// File: tb/sim_xfer_hshk.sv
module sim_xfer_hshk;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CNT_W-1:0] xfer_count = '0;
  logic spec_pio_bit = 1'b0, dor_dma_bit = 1'b0;
  logic byte_rdy = 1'b0, dack_n = 1'b1, io_rd = 1'b0, io_wr = 1'b0, res_rd = 1'b0;
  logic drq, irq, poll_flag, exec_busy;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  xfer_hshk #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .xfer_count(xfer_count),
    .spec_pio_bit(spec_pio_bit), .dor_dma_bit(dor_dma_bit), .byte_rdy(byte_rdy),
    .dack_n(dack_n), .io_rd(io_rd), .io_wr(io_wr), .res_rd(res_rd),
    .drq(drq), .irq(irq), .poll_flag(poll_flag), .exec_busy(exec_busy)
  );

  // Row: start, cnt[4], spec, dor, rdy, dack_n, rd, wr, res | drq irq poll busy
  localparam int NV = 17;
  localparam logic [15:0] VEC [0:NV-1] = '{
    16'b1_0010_0_1_0_1_0_0_0_0001, // R7 DMA start, count 2
    16'b0_0000_0_1_1_1_0_0_0_1001, // R2 request
    16'b0_0000_0_1_0_0_0_0_0_0001, // R3 ack fall clears
    16'b0_0000_0_1_0_0_1_0_0_0001, // R5 read completes byte 1
    16'b0_0000_0_1_0_1_0_0_0_0001,
    16'b0_0000_0_1_0_0_0_0_0_0001,
    16'b0_0000_0_1_1_0_0_0_0_0001, // R4 ready while ack low: deferred
    16'b0_0000_0_1_0_1_0_0_0_1001, // R4 raised after ack high
    16'b0_0000_0_1_0_0_0_0_0_0001, // R3
    16'b0_0000_0_1_0_0_0_1_0_0100, // R7 last byte ends exec
    16'b0_0000_0_1_0_1_0_0_0_0100, // R8 held
    16'b0_0000_0_1_0_1_0_0_1_0000, // R8 released
    16'b1_0001_1_1_0_1_0_0_0_0001, // R1 host mode start
    16'b0_0000_1_1_1_1_0_0_0_0111, // R6 byte irq + poll
    16'b0_0000_1_1_0_1_0_0_0_0111, // R6 held
    16'b0_0000_1_1_0_1_1_0_0_0100, // R6 R7 read clears, result irq
    16'b0_0000_1_1_0_1_0_0_1_0000  // R8
  };

  task automatic step(input logic st, input logic [CNT_W-1:0] cnt, input logic sp,
                      input logic dr, input logic rdy, input logic dk,
                      input logic rd, input logic wr, input logic rs);
    start = st; xfer_count = cnt; spec_pio_bit = sp; dor_dma_bit = dr;
    byte_rdy = rdy; dack_n = dk; io_rd = rd; io_wr = wr; res_rd = rs;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: drq/irq/poll/busy actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {drq, irq, poll_flag, exec_busy};
  endfunction

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2;
    repeat (3) step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    rst = 1'b0;
    chk("R10 reset state", outs(), 4'b0000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][15], CNT_W'(VEC[i][14:11]), VEC[i][10], VEC[i][9], VEC[i][8],
           VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      chk($sformatf("vector row %0d (R1-R8 table)", i), outs(), VEC[i][3:0]);
    end

    // R9: activity in idle is ignored, no stale request afterwards
    step(0, 0, 0, 1, 1, 1, 1, 0, 0);
    step(0, 0, 0, 1, 0, 1, 0, 1, 0);
    chk("R9 idle ignores strobes", outs(), 4'b0000);
    step(1, 1, 0, 1, 0, 1, 0, 0, 0);
    chk("R9 no stale request", outs(), 4'b0001);
    step(0, 0, 0, 1, 1, 1, 0, 0, 0);
    chk("R2 request", outs(), 4'b1001);
    // R5: strobe with ack high does nothing
    step(0, 0, 0, 1, 0, 1, 1, 0, 0);
    chk("R5 strobe ack high ignored", outs(), 4'b1001);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 1, 0, 0);
    chk("R5 R7 completes with ack low", outs(), 4'b0100);
    step(0, 0, 0, 1, 0, 1, 0, 0, 1);

    // R1: both bits 0 -> host mode
    step(1, 1, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 0, 0, 0);
    chk("R1 dor bit 0 gives host mode", outs(), 4'b0111);
    step(0, 0, 0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 1);

    // R1: mode bits changing mid-transfer are ignored
    step(1, 1, 0, 1, 0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 1, 1, 0, 0, 0);
    chk("R1 mode latched at start", outs(), 4'b1001);
    step(0, 0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 1, 0, 0);
    chk("R1 DMA completion kept", outs(), 4'b0100);
    step(0, 0, 1, 0, 0, 1, 0, 0, 1);

    // R7: zero count goes straight to result; R8 hold
    step(1, 0, 0, 1, 0, 1, 0, 0, 0);
    chk("R7 zero count result", outs(), 4'b0100);
    repeat (3) step(0, 0, 0, 1, 0, 1, 0, 0, 0);
    chk("R8 irq held", outs(), 4'b0100);
    step(0, 0, 0, 1, 0, 1, 0, 0, 1);
    chk("R8 released by result read", outs(), 4'b0000);

    // R6: host strobe with no byte pending does not count
    step(1, 1, 1, 1, 0, 1, 0, 0, 0);
    step(0, 0, 1, 1, 0, 1, 0, 1, 0);
    chk("R6 strobe without byte", outs(), 4'b0001);
    step(0, 0, 1, 1, 1, 1, 0, 0, 0);
    step(0, 0, 1, 1, 0, 1, 0, 1, 0);
    chk("R6 R7 write completes", outs(), 4'b0100);
    step(0, 0, 1, 1, 0, 1, 0, 0, 1);
    chk("R8 idle after result", outs(), 4'b0000);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule